// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

A general-purpose I/O port of up to 16 pins that turns pin activity into interrupts. Every pin input is brought into the clock domain by a two-stage synchronizer. Each pin then passes through a detector whose trigger is chosen by a 3-bit field: rising edge, falling edge, either edge, high level or low level. An enabled pin that sees its trigger sets a status bit. Software reads that bit to find the source and clears it by writing a one. A single interrupt line is raised while any enabled, unmasked pin has pending status.

Software reaches the block through a small word-addressed register bus. Reads are combinational. A write takes effect on the clock edge at which `bus_sel` and `bus_wr` are high. The output-data and direction registers drive the pad-side outputs directly and can be read back, so their contents can be saved and restored. Masking has its own write-one-to-set and write-one-to-clear addresses, so no read-modify-write is needed for it. The pin count is a parameter; typical values are 6, 12, 15 and 16.

Top module: `gpio_irq_port`

## Requirements
- R1: A change on `pin_in` is seen by the detectors after two clock edges. Status set by that change can be read at address 8 after the third edge and not before. The synchronized pin levels can be read at address 2.
- R2: The trigger code of pin p is 3 bits wide. For p<8 it sits in the register at address 6, bits 4p+2..4p. For p>=8 it sits in the register at address 7, bits 4(p-8)+2..4(p-8). Codes: 0 falling edge, 1 rising edge, 2 low level, 3 high level, 4 either edge.
- R3: Writing to address 9 clears the status bits written as one, and bits written as zero are left unchanged. Under a level code, status is set again on every cycle that the level stays active, so a clear has no lasting effect while the level persists.
- R4: Writing to address 4 sets the mask bits written as one. Writing to address 5 clears the mask bits written as one. Zero bits leave the mask unchanged. Reading address 4 or address 5 returns the mask.
- R5: A pin sets status only while its bit in the enable register (address 3, read/write) is one. Events that occur while the bit is zero are not recorded later.
- R6: `irq` is high exactly when some pin has status, enable and no mask. Status is still set and readable for a masked pin.
- R7: A status bit set by an edge stays set until it is cleared through address 9, even after the pin returns to its old level.
- R8: Codes 5, 6 and 7 never set status.
- R9: After reset every register, status bit and mask bit reads zero, and `irq`, `pin_out` and `pin_dir` are zero.
- R10: Address 0 (output data) drives `pin_out` and address 1 (direction) drives `pin_dir`. Both are read/write. Bits above the pin count are ignored and read as zero.
- R11: If a clear write to address 9 and a new trigger event on the same pin fall in the same cycle, the status bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | AW (4) | Word address of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, combinational from bus_addr |
| pin_in | input | NPINS (16) | Asynchronous pin levels |
| pin_out | output | NPINS (16) | Output-data register |
| pin_dir | output | NPINS (16) | Direction register (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
A software status clear and a hardware trigger event can land on the same clock edge. The bench provokes this by timing a write to address 9 so that it is captured on the third edge after a pin change, which is the edge on which the either-edge detector fires. It then requires the status bit to read one afterwards, and a later clear with no event pending to read zero. A similar overlap is checked for level codes: a clear issued while the level is held must leave the bit set.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPINS = 16,
  parameter int DW    = 32,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_dir,
  output logic             irq
);
  localparam int STRIDE = 4;
  localparam int PPR    = DW / STRIDE;
  localparam logic [AW-1:0] A_OUT  = AW'(0);
  localparam logic [AW-1:0] A_DIR  = AW'(1);
  localparam logic [AW-1:0] A_IN   = AW'(2);
  localparam logic [AW-1:0] A_EN   = AW'(3);
  localparam logic [AW-1:0] A_MSET = AW'(4);
  localparam logic [AW-1:0] A_MCLR = AW'(5);
  localparam logic [AW-1:0] A_MLO  = AW'(6);
  localparam logic [AW-1:0] A_MHI  = AW'(7);
  localparam logic [AW-1:0] A_STAT = AW'(8);
  localparam logic [AW-1:0] A_ICLR = AW'(9);

  logic [NPINS-1:0] sync1, sync2, prev;
  logic [NPINS-1:0] ien, imask, status, evt;
  logic [DW-1:0]    mode_lo, mode_hi;

  wire              wr_en = bus_sel & bus_wr;
  wire [NPINS-1:0]  wd    = bus_wdata[NPINS-1:0];
  wire [NPINS-1:0]  rise  = sync2 & ~prev;
  wire [NPINS-1:0]  fall  = ~sync2 & prev;
  wire [NPINS-1:0]  clr   = (wr_en && bus_addr == A_ICLR) ? wd : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_out <= '0;
      pin_dir <= '0;
      ien     <= '0;
      imask   <= '0;
      mode_lo <= '0;
      mode_hi <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        A_OUT:  pin_out <= wd;
        A_DIR:  pin_dir <= wd;
        A_EN:   ien     <= wd;
        A_MSET: imask   <= imask | wd;
        A_MCLR: imask   <= imask & ~wd;
        A_MLO:  mode_lo <= bus_wdata;
        A_MHI:  mode_hi <= bus_wdata;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [2:0] code;
    if (i < PPR) begin : g_lo
      assign code = mode_lo[i*STRIDE +: 3];
    end else begin : g_hi
      assign code = mode_hi[(i-PPR)*STRIDE +: 3];
    end
    always_comb begin
      case (code)
        3'd0:    evt[i] = fall[i];
        3'd1:    evt[i] = rise[i];
        3'd2:    evt[i] = ~sync2[i];
        3'd3:    evt[i] = sync2[i];
        3'd4:    evt[i] = rise[i] | fall[i];
        default: evt[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr) | (evt & ien);
  end

  assign irq = |(status & ien & ~imask);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_OUT:          bus_rdata[NPINS-1:0] = pin_out;
      A_DIR:          bus_rdata[NPINS-1:0] = pin_dir;
      A_IN:           bus_rdata[NPINS-1:0] = sync2;
      A_EN:           bus_rdata[NPINS-1:0] = ien;
      A_MSET, A_MCLR: bus_rdata[NPINS-1:0] = imask;
      A_MLO:          bus_rdata = mode_lo;
      A_MHI:          bus_rdata = mode_hi;
      A_STAT:         bus_rdata[NPINS-1:0] = status;
      default:        bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NPINS = 16,
  parameter int DW    = 32,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic             irq,
  input logic [NPINS-1:0] st,
  input logic [NPINS-1:0] en,
  input logic [NPINS-1:0] msk
);
  wire             wr_en   = bus_sel & bus_wr;
  wire [NPINS-1:0] wd      = bus_wdata[NPINS-1:0];
  wire [NPINS-1:0] clr_now = (wr_en && bus_addr == AW'(9)) ? wd : '0;

  a_r4_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == AW'(4)) |=> ((msk & $past(wd)) == $past(wd)));

  a_r4_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == AW'(5)) |=> ((msk & $past(wd)) == '0));

  a_r5_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st & ~$past(st) & ~$past(en)) == '0));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~st & $past(st) & ~$past(clr_now)) == '0));

  a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st != '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq),
  .st(status), .en(ien), .msk(imask)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
  localparam int NP = 16;
  localparam logic [3:0] A_OUT = 0, A_DIR = 1, A_IN = 2, A_EN = 3, A_MSET = 4,
                         A_MCLR = 5, A_MLO = 6, A_MHI = 7, A_STAT = 8, A_ICLR = 9;
  localparam int K_RD = 0, K_IRQ = 1, K_OUT = 2, K_DIR = 3;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [NP-1:0] pin_in = 0, pin_out, pin_dir;
  logic irq;

  always #2 clk = ~clk;

  gpio_irq_port u_dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_dir(pin_dir), .irq(irq));

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        K_IRQ:   act = {31'd0, irq};
        K_OUT:   act = {16'd0, pin_out};
        K_DIR:   act = {16'd0, pin_dir};
        default: act = bus_rdata;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic expect_now(int kind, logic [3:0] a, logic [31:0] e, string tag);
    item_t it;
    bus_sel = (kind == K_RD); bus_wr = 0; bus_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk(logic [3:0] a, logic [31:0] e, string tag);
    tick(); expect_now(K_RD, a, e, tag);
  endtask

  task automatic chk_sig(int kind, logic [31:0] e, string tag);
    tick(); expect_now(kind, 4'd0, e, tag);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    tick(); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick(); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic pins(logic [NP-1:0] v);
    tick(); pin_in = v; tick(); tick(); tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    // R9 reset state
    chk(A_OUT, 0, "R9 out");
    chk(A_DIR, 0, "R9 dir");
    chk(A_EN, 0, "R9 enable");
    chk(A_MSET, 0, "R9 mask");
    chk(A_MLO, 0, "R9 mode0");
    chk(A_STAT, 0, "R9 status");
    chk_sig(K_IRQ, 0, "R9 irq");
    // R10 output data and direction
    wr(A_OUT, 32'h0001_A5A5);
    chk(A_OUT, 32'h0000_A5A5, "R10 out readback");
    chk_sig(K_OUT, 32'hA5A5, "R10 pin_out");
    wr(A_DIR, 32'h00FF);
    chk(A_DIR, 32'h00FF, "R10 dir readback");
    chk_sig(K_DIR, 32'h00FF, "R10 pin_dir");
    // R1 synchronized input readback
    pins(16'h0003);
    chk(A_IN, 32'h0003, "R1 input read");
    pins(16'h0000);
    // R2 rising on pin0, R1 latency, R6 irq, R7 sticky, R3 zero bits
    wr(A_MLO, 32'h1);
    wr(A_EN, 32'h1);
    tick(); pin_in = 16'h0001;
    tick(); tick();
    expect_now(K_RD, A_STAT, 0, "R1 not before third edge");
    tick();
    expect_now(K_RD, A_STAT, 1, "R1 set at third edge");
    chk_sig(K_IRQ, 1, "R6 irq raised");
    pins(16'h0000);
    chk(A_STAT, 1, "R7 sticky after fall");
    wr(A_ICLR, 32'h0);
    chk(A_STAT, 1, "R3 zero bits no effect");
    wr(A_ICLR, 32'h1);
    chk(A_STAT, 0, "R3 clear");
    chk_sig(K_IRQ, 0, "R6 irq dropped");
    // R2 either edge
    wr(A_MLO, 32'h4);
    pins(16'h0001);
    chk(A_STAT, 1, "R2 both rise");
    wr(A_ICLR, 32'h1);
    pins(16'h0000);
    chk(A_STAT, 1, "R2 both fall");
    // R11 clear and event in the same cycle
    tick(); pin_in = 16'h0001;
    tick(); tick();
    bus_sel = 1; bus_wr = 1; bus_addr = A_ICLR; bus_wdata = 32'h1;
    tick(); bus_sel = 0; bus_wr = 0;
    chk(A_STAT, 1, "R11 event wins over clear");
    wr(A_ICLR, 32'h1);
    chk(A_STAT, 0, "R11 later clear");
    // R2 falling
    wr(A_MLO, 32'h0);
    pins(16'h0000);
    chk(A_STAT, 1, "R2 falling");
    wr(A_ICLR, 32'h1);
    // R2 low level on pin5 (mode0 bits 22:20), R3 level reassert
    wr(A_MLO, 32'h0020_0000);
    wr(A_EN, 32'h0020);
    chk(A_STAT, 32'h0020, "R2 low level pin5");
    wr(A_ICLR, 32'h0020);
    chk(A_STAT, 32'h0020, "R3 level reasserts");
    pins(16'h0020);
    wr(A_ICLR, 32'h0020);
    chk(A_STAT, 0, "R3 level gone clear");
    // R2 high level on pin12 (mode1 bits 18:16), R4 mask, R6
    wr(A_MHI, 32'h0003_0000);
    wr(A_EN, 32'h1000);
    pins(16'h1020);
    chk(A_STAT, 32'h1000, "R2 high level pin12");
    wr(A_MSET, 32'h1000);
    chk_sig(K_IRQ, 0, "R6 masked irq");
    chk(A_MCLR, 32'h1000, "R4 mask read");
    chk(A_STAT, 32'h1000, "R6 status while masked");
    wr(A_MCLR, 32'h0);
    chk(A_MSET, 32'h1000, "R4 zero clear bits");
    wr(A_MCLR, 32'h1000);
    chk_sig(K_IRQ, 1, "R6 unmasked irq");
    pins(16'h0000);
    wr(A_ICLR, 32'h1000);
    chk(A_STAT, 0, "R3 pin12 cleared");
    // R8 reserved codes on pin3 (mode0 bits 14:12)
    wr(A_EN, 32'h0008);
    wr(A_MLO, 32'h0000_5000);
    pins(16'h0008); pins(16'h0000);
    chk(A_STAT, 0, "R8 code5");
    wr(A_MLO, 32'h0000_7000);
    pins(16'h0008); pins(16'h0000);
    chk(A_STAT, 0, "R8 code7");
    // R5 enable gating on pin1 rising (mode0 bits 6:4)
    wr(A_MLO, 32'h0000_0010);
    wr(A_EN, 32'h0);
    pins(16'h0002);
    chk(A_STAT, 0, "R5 disabled no status");
    chk_sig(K_IRQ, 0, "R5 disabled no irq");
    wr(A_EN, 32'h0002);
    chk(A_STAT, 0, "R5 not retroactive");
    chk(A_EN, 32'h0002, "R5 enable readback");
    tick(); tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule